// File: doc/BRIEF.md
# Fetch Thread Selector for a Multithreaded Front End

This block decides, every cycle, which hardware threads of a simultaneous multithreaded core are allowed to fetch. It tracks three run-time occupancy figures for each thread: instructions that have entered decode and not yet issued, branches that are still unresolved, and data cache misses that have not yet returned. From those figures, a mode input and a rotating pointer, it ranks the eligible threads and presents up to NSLOT distinct thread numbers. Each number comes with a fetch allowance of BUDGET instructions.

A thread is eligible when its ready flag is set and it is not quiesced, that is, not sleeping while it waits for a memory word to change. The decode, issue, branch-resolve and miss-return stages send one-cycle pulses that move the counters. A per-thread flush clears all of that thread's counters. In the count-based modes, threads with less work in flight go first. In the queue-age mode, a thread whose oldest queued instruction sits nearest the queue head goes last. Ties are always settled by the rotating pointer, so equal threads take turns.

Top module: `fetch_thread_sel`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is asserted, every slot is invalid with thread number 0 and budget 0. All counters clear to zero and the rotation pointer returns to thread 0.
- R2: Only threads with `ready` high and `quiesce` low are selected. The thread numbers in the valid slots differ from each other. Valid slots fill from slot 0 upward, and their number is the smaller of NSLOT and the eligible count. Unused slots show valid 0, thread 0 and budget 0.
- R3: Every valid slot carries a budget equal to BUDGET.
- R4: With mode code 0, or with any of the unused codes 5 to 7, all eligible threads rank equally. They are therefore taken in rotation starting at the pointer.
- R5: With mode code 1, the thread with the smallest decode-to-issue count goes first.
- R6: With mode code 2, the thread with the fewest unresolved branches goes first.
- R7: With mode code 3, the thread with the fewest outstanding cache misses goes first.
- R8: With mode code 4, the thread that presents the larger oldest-entry position in `qpos` goes first, so a smaller (older) position is served later. Thread t uses field `qpos[t*PW +: PW]`.
- R9: Between threads of equal rank, the one at the smaller distance (t - pointer) mod NTHR goes first. After any cycle with at least one valid slot, the pointer moves to one past the thread in the last valid slot; otherwise it holds.
- R10: An increment and a decrement in the same cycle leave a counter unchanged. A counter holds at 2^CW-1 on increment and at 0 on decrement.
- R11: A flush of a thread zeroes all three of its counters at the next edge, and it overrides any pulse in that same cycle.
- R12: The selection is registered. The slots seen after an edge reflect the inputs and the counter values from just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Ranking policy code |
| ready | input | NTHR | Thread has a fetch address ready |
| quiesce | input | NTHR | Thread is sleeping on a memory watch |
| flush | input | NTHR | Clear the thread's counters |
| dec_enter | input | NTHR | Instruction entered decode |
| iss_leave | input | NTHR | Instruction issued |
| br_open | input | NTHR | Branch became unresolved |
| br_close | input | NTHR | Branch resolved |
| miss_open | input | NTHR | Data cache miss started |
| miss_close | input | NTHR | Data cache miss returned |
| qpos | input | NTHR*PW | Per-thread position of the oldest queued entry |
| slot_valid | output | NSLOT | Slot holds a selected thread |
| slot_tid | output | NSLOT*TW | Selected thread number per slot |
| slot_budget | output | NSLOT*BW | Fetch allowance per slot |

## Verification
The hardest behaviour to reach is counter saturation, because the counters can only be seen through the ranking. The stimulus drives one thread past 2^CW-1 increments and a second thread to a value in between. It then narrows `ready` to those two threads so that only their order is visible. A wrapped counter would reverse that order. The same method covers the floor: extra decrements are sent to a thread already at zero, followed by one increment, and the thread is then compared against a neighbour with a known count. A flush is sent in the same cycle as competing pulses and is checked through the miss-count ordering.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    SEL_ROTATE      = 3'd0,
    SEL_DECODE_LOAD = 3'd1,
    SEL_BRANCH_LOAD = 3'd2,
    SEL_MISS_LOAD   = 3'd3,
    SEL_QUEUE_AGE   = 3'd4
  } sel_mode_e;
endpackage

// File: rtl/fts_sat_counter.sv
module fts_sat_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          up,
  input  logic          down,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || flush) cnt <= '0;
    else if (up && !down && cnt != TOP) cnt <= cnt + 1'b1;
    else if (down && !up && cnt != '0) cnt <= cnt - 1'b1;
  end

  assert_hold_top_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && up && !down && !flush) |=> (cnt == TOP));
  assert_hold_floor_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && down && !up && !flush) |=> (cnt == '0));
  assert_net_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (up && down && !flush) |=> $stable(cnt));
  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0));
endmodule

// File: rtl/fts_thread_counters.sv
module fts_thread_counters #(
  parameter int NTHR = 4,
  parameter int CW   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NTHR-1:0]    flush,
  input  logic [NTHR-1:0]    dec_enter,
  input  logic [NTHR-1:0]    iss_leave,
  input  logic [NTHR-1:0]    br_open,
  input  logic [NTHR-1:0]    br_close,
  input  logic [NTHR-1:0]    miss_open,
  input  logic [NTHR-1:0]    miss_close,
  output logic [NTHR*CW-1:0] icnt,
  output logic [NTHR*CW-1:0] bcnt,
  output logic [NTHR*CW-1:0] mcnt
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    fts_sat_counter #(.CW(CW)) u_inst (
      .clk(clk), .rst(rst), .flush(flush[t]),
      .up(dec_enter[t]), .down(iss_leave[t]), .cnt(icnt[t*CW +: CW]));
    fts_sat_counter #(.CW(CW)) u_br (
      .clk(clk), .rst(rst), .flush(flush[t]),
      .up(br_open[t]), .down(br_close[t]), .cnt(bcnt[t*CW +: CW]));
    fts_sat_counter #(.CW(CW)) u_miss (
      .clk(clk), .rst(rst), .flush(flush[t]),
      .up(miss_open[t]), .down(miss_close[t]), .cnt(mcnt[t*CW +: CW]));
  end
endmodule

// File: rtl/fts_ranker.sv
module fts_ranker
  import fts_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int NSLOT = 2,
  parameter int CW    = 4,
  parameter int PW    = 4,
  parameter int TW    = 2
) (
  input  logic [2:0]          mode,
  input  logic [NTHR-1:0]     elig,
  input  logic [TW-1:0]       ptr,
  input  logic [NTHR*CW-1:0]  icnt,
  input  logic [NTHR*CW-1:0]  bcnt,
  input  logic [NTHR*CW-1:0]  mcnt,
  input  logic [NTHR*PW-1:0]  qpos,
  output logic [NSLOT-1:0]    pick_v,
  output logic [NSLOT*TW-1:0] pick_t
);
  localparam int KW = (CW > PW) ? CW : PW;
  localparam int CK = KW + TW;

  logic [CK-1:0] ckey [NTHR];

  always_comb begin
    logic [KW-1:0] k;
    int d;
    for (int t = 0; t < NTHR; t++) begin
      case (sel_mode_e'(mode))
        SEL_DECODE_LOAD: k = KW'(icnt[t*CW +: CW]);
        SEL_BRANCH_LOAD: k = KW'(bcnt[t*CW +: CW]);
        SEL_MISS_LOAD:   k = KW'(mcnt[t*CW +: CW]);
        SEL_QUEUE_AGE:   k = KW'({PW{1'b1}} ^ qpos[t*PW +: PW]);
        default:         k = '0;
      endcase
      d = t - int'(ptr);
      if (d < 0) d = d + NTHR;
      ckey[t] = {k, TW'(d)};
    end
  end

  always_comb begin
    logic [NTHR-1:0] taken;
    logic [CK-1:0]   best;
    logic [TW-1:0]   bt;
    logic            found;
    taken  = '0;
    pick_v = '0;
    pick_t = '0;
    for (int s = 0; s < NSLOT; s++) begin
      found = 1'b0;
      best  = '1;
      bt    = '0;
      for (int t = 0; t < NTHR; t++) begin
        if (elig[t] && !taken[t] && (!found || ckey[t] < best)) begin
          found = 1'b1;
          best  = ckey[t];
          bt    = TW'(t);
        end
      end
      pick_v[s] = found;
      pick_t[s*TW +: TW] = bt;
      if (found) taken[bt] = 1'b1;
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR   = 4,
  parameter int NSLOT  = 2,
  parameter int BUDGET = 4,
  parameter int CW     = 4,
  parameter int PW     = 4,
  localparam int TW    = $clog2(NTHR),
  localparam int BW    = $clog2(BUDGET + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          mode,
  input  logic [NTHR-1:0]     ready,
  input  logic [NTHR-1:0]     quiesce,
  input  logic [NTHR-1:0]     flush,
  input  logic [NTHR-1:0]     dec_enter,
  input  logic [NTHR-1:0]     iss_leave,
  input  logic [NTHR-1:0]     br_open,
  input  logic [NTHR-1:0]     br_close,
  input  logic [NTHR-1:0]     miss_open,
  input  logic [NTHR-1:0]     miss_close,
  input  logic [NTHR*PW-1:0]  qpos,
  output logic [NSLOT-1:0]    slot_valid,
  output logic [NSLOT*TW-1:0] slot_tid,
  output logic [NSLOT*BW-1:0] slot_budget
);
  logic [NTHR*CW-1:0]  icnt, bcnt, mcnt;
  logic [NTHR-1:0]     elig, elig_seen;
  logic [TW-1:0]       ptr, ptr_nxt;
  logic [NSLOT-1:0]    pick_v;
  logic [NSLOT*TW-1:0] pick_t;

  assign elig = ready & ~quiesce;

  fts_thread_counters #(.NTHR(NTHR), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .flush(flush),
    .dec_enter(dec_enter), .iss_leave(iss_leave),
    .br_open(br_open), .br_close(br_close),
    .miss_open(miss_open), .miss_close(miss_close),
    .icnt(icnt), .bcnt(bcnt), .mcnt(mcnt));

  fts_ranker #(.NTHR(NTHR), .NSLOT(NSLOT), .CW(CW), .PW(PW), .TW(TW)) u_rank (
    .mode(mode), .elig(elig), .ptr(ptr),
    .icnt(icnt), .bcnt(bcnt), .mcnt(mcnt), .qpos(qpos),
    .pick_v(pick_v), .pick_t(pick_t));

  always_comb begin
    ptr_nxt = ptr;
    for (int s = 0; s < NSLOT; s++) begin
      if (pick_v[s])
        ptr_nxt = (int'(pick_t[s*TW +: TW]) == NTHR - 1) ? '0 : pick_t[s*TW +: TW] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr         <= '0;
      slot_valid  <= '0;
      slot_tid    <= '0;
      slot_budget <= '0;
      elig_seen   <= '0;
    end else begin
      ptr        <= ptr_nxt;
      slot_valid <= pick_v;
      slot_tid   <= pick_t;
      elig_seen  <= elig;
      for (int s = 0; s < NSLOT; s++)
        slot_budget[s*BW +: BW] <= pick_v[s] ? BW'(BUDGET) : '0;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (slot_valid == '0 && slot_tid == '0));

  assert_slot_count_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_valid) ==
      (($countones(elig_seen) > NSLOT) ? NSLOT : $countones(elig_seen)));

  for (genvar a = 0; a < NSLOT; a++) begin : g_chk
    assert_only_eligible_R2: assert property (@(posedge clk) disable iff (rst)
      slot_valid[a] |-> elig_seen[slot_tid[a*TW +: TW]]);
    if (a + 1 < NSLOT) begin : g_pack
      assert_packed_slots_R2: assert property (@(posedge clk) disable iff (rst)
        slot_valid[a+1] |-> slot_valid[a]);
    end
    for (genvar b = a + 1; b < NSLOT; b++) begin : g_pair
      assert_distinct_tid_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[a] && slot_valid[b]) |->
          (slot_tid[a*TW +: TW] != slot_tid[b*TW +: TW]));
    end
  end
endmodule

// File: tb/fetch_thread_sel_test.sv
`timescale 1ns/1ps
module fetch_thread_sel_test;
  localparam int NT = 4, NS = 2, BUD = 4, CW = 4, PW = 4, TW = 2, BW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] mode = '0;
  logic [NT-1:0] ready = '0, quiesce = '0, flush = '0;
  logic [NT-1:0] dec_enter = '0, iss_leave = '0, br_open = '0, br_close = '0;
  logic [NT-1:0] miss_open = '0, miss_close = '0;
  logic [NT*PW-1:0] qpos = '0;
  logic [NS-1:0] slot_valid;
  logic [NS*TW-1:0] slot_tid;
  logic [NS*BW-1:0] slot_budget;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int m_ic[NT], m_br[NT], m_ms[NT];
  int m_ptr = 0;

  fetch_thread_sel #(.NTHR(NT), .NSLOT(NS), .BUDGET(BUD), .CW(CW), .PW(PW)) uut (
    .clk(clk), .rst(rst), .mode(mode), .ready(ready), .quiesce(quiesce), .flush(flush),
    .dec_enter(dec_enter), .iss_leave(iss_leave), .br_open(br_open), .br_close(br_close),
    .miss_open(miss_open), .miss_close(miss_close), .qpos(qpos),
    .slot_valid(slot_valid), .slot_tid(slot_tid), .slot_budget(slot_budget));

  always #5 clk = ~clk;

  function automatic int keyof(int t);
    case (mode)
      3'd1: return m_ic[t];
      3'd2: return m_br[t];
      3'd3: return m_ms[t];
      3'd4: return ((1 << PW) - 1) - int'(qpos[t*PW +: PW]);
      default: return 0;
    endcase
  endfunction

  function automatic int sat(int v, bit up, bit dn);
    if (up && !dn && v < CMAX) return v + 1;
    if (dn && !up && v > 0) return v - 1;
    return v;
  endfunction

  task automatic step();
    bit ev[NS];
    int et[NS];
    bit taken[NT];
    int last;
    for (int t = 0; t < NT; t++) taken[t] = 0;
    last = -1;
    for (int s = 0; s < NS; s++) begin
      int bk;
      ev[s] = 0; et[s] = 0; bk = 0;
      for (int k = 0; k < NT; k++) begin
        int t;
        t = (m_ptr + k) % NT;
        if (ready[t] && !quiesce[t] && !taken[t] && (!ev[s] || keyof(t) < bk)) begin
          ev[s] = 1; et[s] = t; bk = keyof(t);
        end
      end
      if (ev[s]) begin taken[et[s]] = 1; last = et[s]; end
    end
    @(posedge clk); #1;
    for (int s = 0; s < NS; s++) begin
      int eb;
      eb = ev[s] ? BUD : 0;
      checks++;
      if (slot_valid[s] !== ev[s] || int'(slot_tid[s*TW +: TW]) != et[s] ||
          int'(slot_budget[s*BW +: BW]) != eb) begin
        fails++;
        $display("FAIL %s slot%0d: valid=%0b tid=%0d budget=%0d, expected valid=%0b tid=%0d budget=%0d",
                 cur_req, s, slot_valid[s], slot_tid[s*TW +: TW], slot_budget[s*BW +: BW],
                 ev[s], et[s], eb);
      end
    end
    for (int t = 0; t < NT; t++) begin
      if (flush[t]) begin m_ic[t] = 0; m_br[t] = 0; m_ms[t] = 0; end
      else begin
        m_ic[t] = sat(m_ic[t], dec_enter[t], iss_leave[t]);
        m_br[t] = sat(m_br[t], br_open[t], br_close[t]);
        m_ms[t] = sat(m_ms[t], miss_open[t], miss_close[t]);
      end
    end
    if (last >= 0) m_ptr = (last + 1) % NT;
    flush = '0; dec_enter = '0; iss_leave = '0; br_open = '0; br_close = '0;
    miss_open = '0; miss_close = '0;
  endtask

  task automatic t_reset();
    cur_req = "R1";
    rst = 1'b1; ready = '1;
    repeat (3) begin
      @(posedge clk); #1;
      checks++;
      if (slot_valid !== '0 || slot_tid !== '0 || slot_budget !== '0) begin
        fails++;
        $display("FAIL R1 reset: valid=%b tid=%h budget=%h, expected all 0",
                 slot_valid, slot_tid, slot_budget);
      end
    end
    for (int t = 0; t < NT; t++) begin m_ic[t] = 0; m_br[t] = 0; m_ms[t] = 0; end
    m_ptr = 0;
    rst = 1'b0;
  endtask

  task automatic t_rotate();
    cur_req = "R4 R3 R12"; mode = 3'd0; ready = 4'b1111; quiesce = '0;
    repeat (5) step();
    cur_req = "R2 partial ready"; ready = 4'b0101;
    repeat (3) step();
    cur_req = "R2 quiesced"; quiesce = 4'b0100;
    repeat (2) step();
    cur_req = "R2 none eligible"; ready = 4'b0000;
    repeat (2) step();
    ready = 4'b1111; quiesce = '0;
  endtask

  task automatic t_icount();
    cur_req = "R5"; mode = 3'd1;
    dec_enter = 4'b0111; step();
    dec_enter = 4'b0101; step();
    dec_enter = 4'b0001; step();
    repeat (3) step();
    ready = 4'b0111; repeat (2) step();
    ready = 4'b1111;
    repeat (3) begin iss_leave = 4'b0111; step(); end
  endtask

  task automatic t_branch();
    cur_req = "R6"; mode = 3'd2;
    br_open = 4'b1000; step();
    br_open = 4'b1100; step();
    repeat (3) step();
    ready = 4'b1100; repeat (2) step();
    ready = 4'b1111;
    repeat (2) begin br_close = 4'b1100; step(); end
  endtask

  task automatic t_miss();
    cur_req = "R7"; mode = 3'd3;
    miss_open = 4'b0010; step();
    miss_open = 4'b0011; step();
    repeat (3) step();
    ready = 4'b0011; repeat (2) step();
    ready = 4'b1111;
  endtask

  task automatic t_qage();
    cur_req = "R8"; mode = 3'd4;
    qpos = {4'd2, 4'd9, 4'd9, 4'd0};
    repeat (3) step();
    ready = 4'b1001; repeat (2) step();
    ready = 4'b1111; qpos = '0;
  endtask

  task automatic t_tie();
    cur_req = "R9"; mode = 3'd1; ready = 4'b1011;
    repeat (5) step();
    ready = 4'b1111;
  endtask

  task automatic t_net();
    cur_req = "R10 net"; mode = 3'd1;
    repeat (5) begin dec_enter = 4'b0001; step(); end
    repeat (4) begin dec_enter = 4'b0001; iss_leave = 4'b0001; step(); end
    repeat (3) begin dec_enter = 4'b0010; step(); end
    ready = 4'b0011; repeat (2) step();
    cur_req = "R10 top";
    ready = 4'b1111;
    repeat (20) begin dec_enter = 4'b0100; step(); end
    repeat (10) begin dec_enter = 4'b1000; step(); end
    ready = 4'b1100; repeat (2) step();
    cur_req = "R10 floor";
    ready = 4'b1111;
    repeat (5) begin iss_leave = 4'b0010; step(); end
    dec_enter = 4'b0010; step();
    ready = 4'b0011; repeat (2) step();
    ready = 4'b1111;
  endtask

  task automatic t_flush();
    cur_req = "R11"; mode = 3'd3;
    repeat (3) begin miss_open = 4'b0001; step(); end
    ready = 4'b0011; repeat (2) step();
    flush = 4'b0001; miss_open = 4'b0011; dec_enter = 4'b0001; step();
    repeat (2) step();
    mode = 3'd1; repeat (2) step();
    ready = 4'b1111;
  endtask

  task automatic t_other();
    cur_req = "R4 unused code"; mode = 3'd6;
    repeat (3) step();
    mode = 3'd7; ready = 4'b1110;
    repeat (3) step();
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_icount();
    t_branch();
    t_miss();
    t_qage();
    t_tie();
    t_net();
    t_flush();
    t_other();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule